// File: doc/BRIEF.md
# Radix −2 Add / Subtract / Negate Unit

This block performs arithmetic on fixed-width negabinary operands, where bit k carries the weight (−2)^k. It accepts two operands and an operation code when an input strobe is asserted. It returns the registered result one clock later, together with a valid flag and an overflow flag. The unit contains one arithmetic primitive: a ripple negabinary adder whose inter-digit carry takes the values −1, 0 or +1.

The other two operations are built around that adder using bitwise inversion only. Inverting all bits of an n-bit negabinary word X yields the word for B − X, where B is the all-ones word, that is, the sum of (−2)^k over every position. Subtraction inverts the first operand, adds the second and inverts the sum, which gives A − B. Negation adds the operand to the all-ones word and inverts the sum, which gives −A. The subtrahend is never doubled, shifted or otherwise negated.

An n-bit word represents the integers from the sum of its negative weights up to the sum of its positive weights. For n = 4 that range is −10 to +5.

Top module: `nb_arith_unit`

## Requirements
- R1: With `op` = 2'b00, the result is the negabinary encoding of A + B.
- R2: With `op` = 2'b01, the result is the negabinary encoding of A − B.
- R3: With `op` = 2'b10, the result is the negabinary encoding of −A, and `opb` has no effect on it.
- R4: `overflow` is 1 exactly when the true mathematical result of the requested operation lies outside the range representable in WIDTH negabinary digits. When `overflow` is 0, `result` is exact.
- R5: With `op` = 2'b11, the unit behaves exactly as for addition.
- R6: `out_valid` is high in the cycle after a cycle in which `in_valid` was sampled high, and low otherwise. `result` and `overflow` reflect the operation captured on that strobe.
- R7: While `in_valid` is low, `result` and `overflow` keep their previous values.
- R8: During and right after reset, `out_valid`, `overflow` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 00 add, 01 subtract, 10 negate, 11 add |
| opa | input | WIDTH | Operand A (minuend, or value to negate) |
| opb | input | WIDTH | Operand B (addend or subtrahend) |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | WIDTH | Negabinary result |
| overflow | output | 1 | True result not representable |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing;
- that the outputs hold when no strobe arrives;
- the algebraic identities that need no arithmetic model: adding zero, subtracting a value from itself, and negating zero.

Only the bench's sweeps can show correct digits and correct overflow decisions for general operands. The bench covers every operand pair for every opcode at WIDTH = 4, and compares the decoded result against integer arithmetic and the representable range.

// File: rtl/nb_pkg.sv
package nb_pkg;

  typedef enum logic [1:0] {
    NB_OP_ADD = 2'b00,
    NB_OP_SUB = 2'b01,
    NB_OP_NEG = 2'b10,
    NB_OP_ALT = 2'b11
  } nb_op_e;

  // Carry between digits: two's complement, legal values -1, 0, +1.
  typedef logic [1:0] nb_carry_t;

  localparam nb_carry_t NB_CY_ZERO = 2'b00;
  localparam nb_carry_t NB_CY_POS  = 2'b01;
  localparam nb_carry_t NB_CY_NEG  = 2'b11;

endpackage

// File: rtl/nb_digit_cell.sv
module nb_digit_cell
  import nb_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  input  nb_carry_t cy_i,
  output logic      d_o,
  output nb_carry_t cy_o
);

  // Signed local sum in the range -1 .. +3.
  logic signed [2:0] sum_s;

  always_comb begin
    sum_s = $signed({2'b00, a_i}) + $signed({2'b00, b_i})
          + $signed({cy_i[1], cy_i});
    d_o   = sum_s[0];
    // The digit weight of the next position is -2 times this one, so
    // sum = digit - 2*carry_out.
    unique case (sum_s)
      -3'sd1:  cy_o = NB_CY_POS;
      3'sd0:   cy_o = NB_CY_ZERO;
      3'sd1:   cy_o = NB_CY_ZERO;
      3'sd2:   cy_o = NB_CY_NEG;
      3'sd3:   cy_o = NB_CY_NEG;
      default: cy_o = NB_CY_ZERO;
    endcase
  end

endmodule

// File: rtl/nb_ripple_adder.sv
module nb_ripple_adder
  import nb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] s_o,
  output nb_carry_t        cy_o
);

  nb_carry_t chain [0:WIDTH];

  assign chain[0] = NB_CY_ZERO;

  for (genvar k = 0; k < WIDTH; k++) begin : g_pos
    nb_digit_cell u_cell (
      .a_i  (x_i[k]),
      .b_i  (y_i[k]),
      .cy_i (chain[k]),
      .d_o  (s_o[k]),
      .cy_o (chain[k+1])
    );
  end

  assign cy_o = chain[WIDTH];

endmodule

// File: rtl/nb_operand_stage.sv
module nb_operand_stage
  import nb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] y_o,
  output logic             flip_o
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  nb_op_e op_e;

  always_comb begin
    op_e   = nb_op_e'(op_i);
    x_o    = a_i;
    y_o    = b_i;
    flip_o = 1'b0;
    unique case (op_e)
      NB_OP_SUB: begin
        // Complemented minuend plus subtrahend, complemented afterwards.
        x_o    = ~a_i;
        y_o    = b_i;
        flip_o = 1'b1;
      end
      NB_OP_NEG: begin
        // Operand plus the all-ones base, complemented afterwards.
        x_o    = a_i;
        y_o    = ALL_ONES;
        flip_o = 1'b1;
      end
      default: begin
        x_o    = a_i;
        y_o    = b_i;
        flip_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/nb_arith_unit.sv
module nb_arith_unit
  import nb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             overflow
);

  logic [WIDTH-1:0] add_x, add_y, add_s;
  logic             flip;
  nb_carry_t        add_cy;

  logic [WIDTH-1:0] result_d, result_q;
  logic             ovf_d, ovf_q;
  logic             vld_d, vld_q;
  logic             load_en;

  nb_operand_stage #(.WIDTH(WIDTH)) u_stage (
    .op_i   (op),
    .a_i    (opa),
    .b_i    (opb),
    .x_o    (add_x),
    .y_o    (add_y),
    .flip_o (flip)
  );

  nb_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .x_i  (add_x),
    .y_i  (add_y),
    .s_o  (add_s),
    .cy_o (add_cy)
  );

  // Next-state logic.
  always_comb begin
    load_en  = in_valid;
    vld_d    = in_valid;
    result_d = result_q;
    ovf_d    = ovf_q;
    if (load_en) begin
      result_d = flip ? ~add_s : add_s;
      ovf_d    = (add_cy != NB_CY_ZERO);
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (load_en) begin
        result_q <= result_d;
        ovf_q    <= ovf_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = result_q;
  assign overflow  = ovf_q;

endmodule

// File: rtl/nb_arith_unit_chk.sv
module nb_arith_unit_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       op,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             out_valid,
  input logic [WIDTH-1:0] result,
  input logic             overflow
);

  a_r6_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r6_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(overflow)));

  a_r1_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b00 && opb == '0) |=>
      (result == $past(opa) && !overflow));

  a_r2_sub_self: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b01 && opa == opb) |=> (result == '0 && !overflow));

  a_r3_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b10 && opa == '0) |=> (result == '0 && !overflow));

  always_comb begin
    if (!rst_n) begin
      a_r8_reset_state: assert (out_valid == 1'b0);
    end
  end

endmodule

bind nb_arith_unit nb_arith_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_nb_arith_unit.sv
module sim_nb_arith_unit;

  localparam int W      = 4;
  localparam int PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   op;
  logic [W-1:0] opa, opb;
  logic         out_valid;
  logic [W-1:0] result;
  logic         overflow;

  int n_checks = 0;
  int n_fail   = 0;
  int lo_lim   = 0;
  int hi_lim   = 0;

  nb_arith_unit #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
    .overflow(overflow)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic int nb_val(input logic [W-1:0] v);
    int acc = 0;
    for (int k = 0; k < W; k++)
      if (v[k]) acc += (k % 2 == 0) ? (1 << k) : -(1 << k);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [W-1:0] a,
                        input logic [W-1:0] b, input string req);
    int  truth;
    bit  oor;
    @(negedge clk);
    op = o; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    case (o)
      2'b01:   truth = nb_val(a) - nb_val(b);
      2'b10:   truth = -nb_val(a);
      default: truth = nb_val(a) + nb_val(b);
    endcase
    oor = (truth < lo_lim) || (truth > hi_lim);
    // R6: valid one cycle after strobe
    check(out_valid == 1'b1, "R6 valid", int'(out_valid), 1);
    // R4: overflow iff out of range
    check(overflow == oor, "R4 overflow", int'(overflow), int'(oor));
    if (!oor) check(nb_val(result) == truth, req, nb_val(result), truth);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog R6 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [W-1:0] keep_r;
    logic         keep_o;
    for (int k = 0; k < W; k++)
      if (k % 2 == 0) hi_lim += (1 << k); else lo_lim -= (1 << k);

    rst_n = 1'b0; in_valid = 1'b0; op = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(out_valid == 1'b0, "R8 valid", int'(out_valid), 0);
    check(result == '0, "R8 result", int'(result), 0);
    check(overflow == 1'b0, "R8 overflow", int'(overflow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && result == '0, "R8 after release", int'(result), 0);

    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++) begin
        run_op(2'b00, W'(a), W'(b), "R1 add");
        run_op(2'b01, W'(a), W'(b), "R2 sub");
        run_op(2'b10, W'(a), W'(b), "R3 neg (opb ignored)");
        run_op(2'b11, W'(a), W'(b), "R5 alt add");
      end

    // R7: outputs hold with no strobe, even when operands change
    run_op(2'b01, W'(3), W'(9), "R2 sub");
    keep_r = result; keep_o = overflow;
    opa = W'(12); opb = W'(5); op = 2'b10;
    repeat (3) @(negedge clk);
    check(result == keep_r, "R7 hold result", int'(result), int'(keep_r));
    check(overflow == keep_o, "R7 hold overflow", int'(overflow), int'(keep_o));
    check(out_valid == 1'b0, "R6 valid drop", int'(out_valid), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule